// File: doc/BRIEF.md
# R-R Interval Irregularity Detector

This block watches a stream of baseline-corrected, signed 8-bit ECG samples and decides once per fixed window whether the heartbeat rhythm is irregular. Each sample is band-pass filtered by an 80-tap FIR filter. A single multiply-accumulate unit walks the taps one per clock between input samples. The block takes the difference between successive filter outputs as the slope. It declares a QRS peak when that slope rises above a programmable threshold. After each peak, detection is held off for a programmable number of samples.

The distance in samples between successive peaks of the same window is the R-R interval. Over each window the block accumulates the interval count, the interval sum and the sum of squared intervals. It never divides. At the end of the window it tests whether the variance, the mean of the squares minus the square of the mean, exceeds a programmable limit. To do so it compares `n*S2 - S1*S1` with `limit*n*n`. A flagged window sets a sticky interrupt, which the host clears with a register write. The filter coefficients and the thresholds are loaded through a simple write port.

Windows are `WIN_LEN` accepted samples long (5000 by default, 10 s at 500 Hz) and never overlap. Samples must arrive at least `NTAPS + 4` clocks apart.

Top module: `rr_rhythm_detector`

## Requirements
- R1: After reset, `irq`, `win_done` and `peak_seen` are low, all coefficients are zero, the slope threshold is 20, the hold-off length is 100 and the variance limit is 400.
- R2: The filter output for sample n is `(sum over k of c[k]*x[n-k]) >>> 8`, using signed 12-bit coefficients c[k] written at register address k (0..79) and signed samples x. A `smp_valid` pulse that arrives while the multiply-accumulate is still busy with the previous sample is dropped and does not advance the sample count.
- R3: The slope is the filter output minus the previous filter output. A peak is declared only when the slope is strictly greater than the unsigned slope threshold at address 0x80. Each declared peak gives a one-cycle `peak_seen` pulse.
- R4: After a peak at sample p, samples p+1 through p+H cannot be peaks. H is the hold-off length at address 0x81. The hold-off carries across window boundaries.
- R5: An interval is the sample-index difference between two successive peaks in the same window. The first peak of a window opens no interval.
- R6: A window is `WIN_LEN` consecutive accepted samples. A peak on the last sample of a window belongs to that window. `win_done` pulses once after the last sample of each window, and the window statistics then restart empty.
- R7: `win_irregular`, valid with `win_done`, is high exactly when the mean of the squared intervals minus the squared mean interval is strictly greater than the variance limit at address 0x82.
- R8: `irq` rises in the cycle after `win_done` with `win_irregular` high. It stays high until a write to address 0x83 with data bit 0 set. A new flag in the same cycle as a clear wins over the clear.
- R9: A window with fewer than three peaks (fewer than two intervals) is never reported irregular, whatever its intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe for a new sample |
| smp_data | input | 8 | Signed ECG sample |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Write address: coefficients below 0x80, controls at 0x80..0x83 |
| reg_wdata | input | 32 | Write data |
| peak_seen | output | 1 | One-cycle pulse for each declared peak |
| win_done | output | 1 | One-cycle pulse at the end of each window |
| win_irregular | output | 1 | Window verdict, valid with `win_done` |
| irq | output | 1 | Sticky irregular-rhythm interrupt |

## Verification
Several properties are checked on every cycle:
- the tap index stays in range;
- a sample strobe during a busy filter leaves the delay line untouched;
- the hold-off counter loads on every peak and suppresses peaks while it is non-zero;
- window statistics are empty when a window closes, and a window with fewer than two intervals is never flagged;
- the interrupt rises only after a flagged window and falls only on a clear write.

Other behaviours only the bench scenarios can show, by comparing against a separate sample-by-sample model:
- the filtered values and the exact peak positions;
- the strict slope comparison;
- the variance verdict for regular and irregular rhythms, including a peak on a window's last sample, the hold-off crossing a window boundary and a raised variance limit.

// File: rtl/rr_det_pkg.sv
package rr_det_pkg;

  localparam logic [7:0] ADDR_SLOPE = 8'h80;
  localparam logic [7:0] ADDR_HOLD  = 8'h81;
  localparam logic [7:0] ADDR_VAR   = 8'h82;
  localparam logic [7:0] ADDR_CLR   = 8'h83;

  typedef struct packed {
    logic [15:0] slope_thr;
    logic [15:0] hold_len;
    logic [31:0] var_lim;
  } rr_cfg_t;

  // Variance test without division: n*S2 - S1^2 > lim*n^2
  function automatic logic is_irregular(input logic [31:0] n,
                                        input logic [63:0] s1,
                                        input logic [63:0] s2,
                                        input logic [31:0] lim);
    logic [63:0] lhs;
    logic [63:0] rhs;
    if (n < 32'd2) return 1'b0;
    lhs = 64'(n) * s2 - s1 * s1;
    rhs = 64'(lim) * 64'(n) * 64'(n);
    return lhs > rhs;
  endfunction

endpackage

// File: rtl/rr_fir_mac.sv
module rr_fir_mac #(
  parameter int NTAPS     = 80,
  parameter int SMP_W     = 8,
  parameter int COEF_W    = 12,
  parameter int COEF_FRAC = 8,
  localparam int IDX_W    = $clog2(NTAPS),
  localparam int Y_W      = SMP_W + COEF_W + IDX_W + 1 - COEF_FRAC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [SMP_W-1:0]  smp_data,
  input  logic                     coef_we,
  input  logic [IDX_W-1:0]         coef_idx,
  input  logic signed [COEF_W-1:0] coef_val,
  output logic                     y_vld,
  output logic signed [Y_W-1:0]    y_val
);

  localparam int PROD_W = SMP_W + COEF_W;
  localparam int ACC_W  = PROD_W + IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST_TAP = IDX_W'(NTAPS - 1);

  logic signed [SMP_W-1:0]  dline    [NTAPS];
  logic signed [COEF_W-1:0] coef_mem [NTAPS];
  logic                     busy;
  logic [IDX_W-1:0]         tap;
  logic signed [ACC_W-1:0]  acc;
  logic signed [PROD_W-1:0] prod;
  logic                     start;

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [PROD_W-1:0] p);
    return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  assign start = smp_valid && !busy;
  assign prod  = coef_mem[tap] * dline[tap];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) coef_mem[i] <= '0;
    end else if (coef_we) begin
      coef_mem[coef_idx] <= coef_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) dline[i] <= '0;
    end else if (start) begin
      dline[0] <= smp_data;
      for (int i = 1; i < NTAPS; i++) dline[i] <= dline[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tap   <= '0;
      acc   <= '0;
      y_vld <= 1'b0;
    end else begin
      y_vld <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        tap  <= '0;
        acc  <= '0;
      end else if (busy) begin
        acc <= acc + widen(prod);
        if (tap == LAST_TAP) begin
          busy  <= 1'b0;
          y_vld <= 1'b1;
        end else begin
          tap <= tap + 1'b1;
        end
      end
    end
  end

  assign y_val = acc[ACC_W-1:COEF_FRAC];

  // R2
  tap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, tap} < (IDX_W+1)'(NTAPS)));
  // R2
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && smp_valid) |=> $stable(dline[0]));
  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |-> !busy);

endmodule

// File: rtl/rr_peak_gate.sv
module rr_peak_gate #(
  parameter int Y_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  y_vld,
  input  logic signed [Y_W-1:0] y_val,
  input  logic [15:0]           slope_thr,
  input  logic [15:0]           hold_len,
  output logic                  tick,
  output logic                  hit
);

  localparam int S_W = (Y_W + 1 > 17) ? Y_W + 1 : 17;

  logic signed [Y_W-1:0] y_prev;
  logic signed [S_W-1:0] slope;
  logic signed [S_W-1:0] thr_s;
  logic [15:0]           hold;
  logic                  fire;

  function automatic logic signed [S_W-1:0] diff(input logic signed [Y_W-1:0] a,
                                                 input logic signed [Y_W-1:0] b);
    return S_W'(a) - S_W'(b);
  endfunction

  assign slope = diff(y_val, y_prev);
  assign thr_s = $signed(S_W'(slope_thr));
  assign fire  = y_vld && (hold == 16'd0) && (slope > thr_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_prev <= '0;
      hold   <= '0;
      tick   <= 1'b0;
      hit    <= 1'b0;
    end else begin
      tick <= y_vld;
      hit  <= fire;
      if (y_vld) begin
        y_prev <= y_val;
        if (fire)             hold <= hold_len;
        else if (hold != '0)  hold <= hold - 16'd1;
      end
    end
  end

  // R4
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hold == $past(hold_len)));
  // R4
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_vld && hold != 16'd0) |=> !hit);
  // R3
  hit_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> tick);

endmodule

// File: rtl/rr_win_stats.sv
module rr_win_stats #(
  parameter int WIN_LEN = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        hit,
  input  logic [31:0] var_lim,
  output logic        done,
  output logic        irregular
);
  import rr_det_pkg::*;

  localparam int WC_W = $clog2(WIN_LEN);
  localparam int IV_W = $clog2(WIN_LEN + 1);
  localparam int S2_W = 2 * IV_W;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN_LEN - 1);
  localparam logic [IV_W-1:0] IV_MAX  = '1;

  logic [WC_W-1:0] wcnt;
  logic [IV_W-1:0] since;
  logic            has_prev;
  logic [IV_W-1:0] n_int;
  logic [IV_W-1:0] s1;
  logic [S2_W-1:0] s2;
  logic            eval_pend;
  logic            last;

  function automatic logic [S2_W-1:0] sq(input logic [IV_W-1:0] v);
    return S2_W'(v) * S2_W'(v);
  endfunction

  assign last = tick && (wcnt == WC_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt      <= '0;
      since     <= '0;
      has_prev  <= 1'b0;
      n_int     <= '0;
      s1        <= '0;
      s2        <= '0;
      eval_pend <= 1'b0;
      done      <= 1'b0;
      irregular <= 1'b0;
    end else begin
      eval_pend <= last;
      done      <= eval_pend;
      if (tick) begin
        wcnt <= last ? '0 : wcnt + 1'b1;
        if (hit) begin
          since    <= IV_W'(1);
          has_prev <= 1'b1;
          if (has_prev) begin
            n_int <= n_int + 1'b1;
            s1    <= s1 + since;
            s2    <= s2 + sq(since);
          end
        end else if (since != IV_MAX) begin
          since <= since + 1'b1;
        end
      end
      if (eval_pend) begin
        irregular <= is_irregular(32'(n_int), 64'(s1), 64'(s2), var_lim);
        n_int     <= '0;
        s1        <= '0;
        s2        <= '0;
        has_prev  <= 1'b0;
      end
    end
  end

  // R6
  wcnt_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, wcnt} < (WC_W+1)'(WIN_LEN));
  // R6
  win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (n_int == '0 && !has_prev && s2 == '0));
  // R9
  few_peaks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_pend && n_int < IV_W'(2)) |=> !irregular);

endmodule

// File: rtl/rr_rhythm_detector.sv
module rr_rhythm_detector #(
  parameter int NTAPS     = 80,
  parameter int SMP_W     = 8,
  parameter int COEF_W    = 12,
  parameter int COEF_FRAC = 8,
  parameter int WIN_LEN   = 5000,
  parameter int SLOPE_DEF = 20,
  parameter int HOLD_DEF  = 100,
  parameter int VAR_DEF   = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic             peak_seen,
  output logic             win_done,
  output logic             win_irregular,
  output logic             irq
);
  import rr_det_pkg::*;

  localparam int IDX_W = $clog2(NTAPS);
  localparam int Y_W   = SMP_W + COEF_W + IDX_W + 1 - COEF_FRAC;

  rr_cfg_t               cfg;
  logic                  coef_we;
  logic                  clr_wr;
  logic                  flag_set;
  logic                  y_vld;
  logic signed [Y_W-1:0] y_val;
  logic                  pk_tick;
  logic                  pk_hit;

  assign coef_we  = reg_wr && ({1'b0, reg_addr} < 9'(NTAPS));
  assign clr_wr   = reg_wr && (reg_addr == ADDR_CLR) && reg_wdata[0];
  assign flag_set = win_done && win_irregular;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.slope_thr <= 16'(SLOPE_DEF);
      cfg.hold_len  <= 16'(HOLD_DEF);
      cfg.var_lim   <= 32'(VAR_DEF);
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_SLOPE: cfg.slope_thr <= reg_wdata[15:0];
        ADDR_HOLD:  cfg.hold_len  <= reg_wdata[15:0];
        ADDR_VAR:   cfg.var_lim   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= flag_set | (irq & ~clr_wr);
  end

  rr_fir_mac #(
    .NTAPS(NTAPS), .SMP_W(SMP_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
  ) u_fir (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_data($signed(smp_data)),
    .coef_we(coef_we), .coef_idx(reg_addr[IDX_W-1:0]),
    .coef_val($signed(reg_wdata[COEF_W-1:0])),
    .y_vld(y_vld), .y_val(y_val)
  );

  rr_peak_gate #(.Y_W(Y_W)) u_peak (
    .clk(clk), .rst_n(rst_n),
    .y_vld(y_vld), .y_val(y_val),
    .slope_thr(cfg.slope_thr), .hold_len(cfg.hold_len),
    .tick(pk_tick), .hit(pk_hit)
  );

  rr_win_stats #(.WIN_LEN(WIN_LEN)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .tick(pk_tick), .hit(pk_hit), .var_lim(cfg.var_lim),
    .done(win_done), .irregular(win_irregular)
  );

  assign peak_seen = pk_hit;

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> irq);
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(flag_set));

endmodule

// File: tb/tb_rr_rhythm_detector.sv
`timescale 1ns/1ps
module tb_rr_rhythm_detector;

  localparam int NT   = 80;
  localparam int WIN  = 200;
  localparam int GAP  = 88;
  localparam int MAXS = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_data = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        peak_seen, win_done, win_irregular, irq;

  always #2.5 clk = ~clk;

  rr_rhythm_detector #(.WIN_LEN(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .peak_seen(peak_seen), .win_done(win_done),
    .win_irregular(win_irregular), .irq(irq)
  );

  int  n_chk = 0, n_bad = 0;
  bit  finished = 0;
  int  peak_q[$];
  bit  verdict_q[$];
  int  coefs[NT];
  int  xs[MAXS];
  int  spk[WIN];
  int  drv_idx = -1;
  int  m_slope = 20, m_hold = 100, m_lim = 400;
  int  m_yprev = 0, m_last_pk = -100000, m_prev_in_win = -1;
  real m_cnt = 0.0, m_sum = 0.0, m_sq = 0.0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Reference model step for accepted sample n
  task automatic model_step(input int n);
    int acc = 0;
    int y, slope;
    real mean, var_v;
    for (int k = 0; k < NT; k++) if (n - k >= 0) acc += coefs[k] * xs[n-k];
    y = acc >>> 8;
    slope = y - m_yprev;
    m_yprev = y;
    if (slope > m_slope && (n - m_last_pk) > m_hold) begin
      peak_q.push_back(n);
      if (m_prev_in_win >= 0) begin
        m_cnt += 1.0;
        m_sum += real'(n - m_prev_in_win);
        m_sq  += real'(n - m_prev_in_win) * real'(n - m_prev_in_win);
      end
      m_prev_in_win = n;
      m_last_pk = n;
    end
    if (n % WIN == WIN - 1) begin
      if (m_cnt >= 2.0) begin
        mean  = m_sum / m_cnt;
        var_v = m_sq / m_cnt - mean * mean;
        verdict_q.push_back(var_v > real'(m_lim));
      end else begin
        verdict_q.push_back(1'b0);
      end
      m_cnt = 0.0; m_sum = 0.0; m_sq = 0.0; m_prev_in_win = -1;
    end
  endtask

  task automatic send_sample(input int v, input bit poke);
    @(negedge clk);
    drv_idx++;
    xs[drv_idx] = v;
    model_step(drv_idx);
    smp_valid = 1'b1; smp_data = 8'(v);
    @(negedge clk);
    smp_valid = 1'b0;
    for (int c = 0; c < GAP - 1; c++) begin
      if (poke && c == 10) begin
        smp_valid = 1'b1; smp_data = 8'd120;
      end else begin
        smp_valid = 1'b0;
      end
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  task automatic play_window(input int poke_at);
    for (int i = 0; i < WIN; i++) send_sample(spk[i], i == poke_at);
    for (int i = 0; i < WIN; i++) spk[i] = 0;
    repeat (10) @(negedge clk);
  endtask

  // Monitor: pops expected peaks and window verdicts
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (peak_seen) begin
        if (peak_q.size() == 0) check(1'b0, "R3 unexpected peak", drv_idx, -1);
        else begin
          int e;
          e = peak_q.pop_front();
          check(e == drv_idx, "R3/R4 peak sample", drv_idx, e);
        end
      end
      if (win_done) begin
        if (verdict_q.size() == 0) check(1'b0, "R6 unexpected window", 1, 0);
        else begin
          bit e;
          e = verdict_q.pop_front();
          check(e == win_irregular, "R7 window verdict", int'(win_irregular), int'(e));
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) coefs[i] = 0;
    for (int i = 0; i < WIN; i++) spk[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irq == 1'b0, "R1 irq", int'(irq), 0);
    check(win_done == 1'b0, "R1 win_done", int'(win_done), 0);
    check(peak_seen == 1'b0, "R1 peak_seen", int'(peak_seen), 0);

    // identity filter: c[0] = 1.0 in Q8
    wr(8'd0, 32'd256); coefs[0] = 256;
    wr(8'h80, 32'd50); m_slope = 50;
    wr(8'h81, 32'd10); m_hold = 10;
    wr(8'h82, 32'd20); m_lim = 20;

    // W1 regular; slope exactly at threshold is no peak (R3); busy strobe dropped (R2)
    spk[10] = 100; spk[50] = 100; spk[90] = 100; spk[130] = 100; spk[170] = 100;
    spk[30] = 50;
    play_window(70);

    // W2 irregular intervals 20,60,20,70 (R7)
    spk[10] = 100; spk[30] = 100; spk[90] = 100; spk[110] = 100; spk[180] = 100;
    play_window(-1);
    check(irq == 1'b1, "R8 irq set after flagged window", int'(irq), 1);

    // W3 two peaks only (R9); irq stays (R8)
    spk[20] = 100; spk[150] = 100;
    play_window(-1);
    check(irq == 1'b1, "R8 irq sticky", int'(irq), 1);
    wr(8'h83, 32'd1);
    @(negedge clk);
    check(irq == 1'b0, "R8 irq cleared", int'(irq), 0);

    // W4 extra spike inside hold-off (R4)
    spk[10] = 100; spk[14] = 100; spk[50] = 100; spk[90] = 100; spk[130] = 100;
    play_window(-1);

    // W5 peak on last sample of window (R6)
    spk[30] = 100; spk[60] = 100; spk[90] = 100; spk[199] = 100;
    play_window(-1);
    wr(8'h83, 32'd1);

    // W6 hold-off crosses boundary, fresh interval chain (R5)
    spk[5] = 100; spk[45] = 100; spk[85] = 100; spk[125] = 100; spk[165] = 100;
    play_window(-1);
    check(irq == 1'b0, "R5 no irq after regular window", int'(irq), 0);

    // W7 delay filter c[5] (R2)
    wr(8'd0, 32'd0); coefs[0] = 0;
    wr(8'd5, 32'd256); coefs[5] = 256;
    spk[20] = 100; spk[60] = 100; spk[100] = 100; spk[140] = 100;
    play_window(-1);

    // W8 W2 pattern with raised limit (R7)
    wr(8'h82, 32'd1000); m_lim = 1000;
    spk[10] = 100; spk[30] = 100; spk[90] = 100; spk[110] = 100; spk[180] = 100;
    play_window(-1);
    check(irq == 1'b0, "R7 raised limit keeps irq low", int'(irq), 0);

    repeat (100) @(negedge clk);
    check(peak_q.size() == 0, "R3 missing peaks", peak_q.size(), 0);
    check(verdict_q.size() == 0, "R6 missing windows", verdict_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R6 run did not complete actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule